// File: doc/BRIEF.md
# Wake-Pin Interrupt and Routing Controller

This block watches a small set of external wake pins, up to four of them. Each pin passes through a two-flop synchroniser and is then compared against a trigger mode set for that pin. The modes are level low, level high, falling edge, rising edge, either edge, or disabled. A detected event sets a status bit. Software enables those bits and acknowledges them through a write-one-to-clear register.

A routing register gates the pending pin events, and three peripheral event inputs, onto two registered outputs. The peripheral inputs are a real-time clock, an infrared receiver and a watchdog. One output is an interrupt line and the other is a wake-request line. Every source has a separate enable for each of the two outputs. Software reaches the block over a plain 32-bit register bus with address, write enable, write data and combinational read data.

Top module: `wake_pin_ctrl`

## Requirements
- R1: After reset the status, enable and route registers read 0, and irq_o and wake_o are 0. Each pin configuration register reads 0x8, which is the disabled mode plus the pin level bit (0 while the pin is low).
- R2: Pin n's configuration register sits at 0x330+8n. Bit 0 is read-only and returns the synchronised pin level. Bits 3:1 are the read/write trigger mode, and bit 4 is the read/write event-hold bit. All other bits read 0.
- R3: In mode 3 (rising edge) a 0-to-1 pin transition sets status bit n at 0x310. The bit stays set until a 1 is written to bit n of the clear register at 0x318.
- R4: In mode 2 (falling edge) a 1-to-0 transition sets the status bit. In mode 6 (either edge) both directions set it. In both modes the bit is sticky until cleared, and a steady pin sets nothing.
- R5: In mode 1 (level high) and mode 0 (level low) the status bit follows the live synchronised pin condition. A clear while the condition persists leaves the bit set.
- R6: Mode 4 (disabled), and the unused codes 5 and 7, never set a status bit, whatever the pin does.
- R7: Writing 0 to a clear-register bit has no effect. A clear and a new edge in the same clock cycle leave the status bit set.
- R8: A pin is pending when its status bit and its enable bit (0x314, bit n) are both 1. irq_o is 1 one clock after any pending pin has its route bit 8+n set. It is also 1 after any peripheral event has its route bit set: bit 0 for the clock, bit 1 for infrared, bit 2 for the watchdog (perip_evt_i bits 0, 1, 2).
- R9: wake_o is 1 one clock after any pending pin has route bit 24+n set, or any peripheral event has route bit 16+k set. The wake enables are independent of the interrupt enables.
- R10: While a pin's hold bit (configuration bit 4) is 1, its status bit reads 0 in every mode.
- R11: The route register at 0x31C keeps only bits 27:24, 18:16, 11:8 and 2:0, and reads 0 elsewhere. The clear register, the second per-pin register at 0x334+8n, and every unmapped offset read 0, and writes to them store nothing.
- R12: Software may put every pin in mode 4, write the enable register to 0, and then turn on all routing while the pins toggle. Throughout that sequence irq_o and wake_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register byte address |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| wake_pin_i | input | 4 | Asynchronous wake pins |
| perip_evt_i | input | 3 | Peripheral events: bit 0 clock, bit 1 infrared, bit 2 watchdog |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Combined wake request |

## Verification
The bench drives the same pin through every trigger code, with a transition before and after an acknowledge. A level mode that latched would keep a stale bit, and an edge mode that followed the level would lose the event. The bench lands a clear write in exactly the cycle an edge is detected. A design that gave the clear priority would drop that event. It also sets the hold bit under an active level, which a broken hold would let through. Finally, it toggles the pins during the quiet setup sequence, where any glitch from an unsynchronised or non-disabled pin would show up on irq_o or wake_o.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
  localparam int unsigned DW = 32;

  localparam logic [2:0] TRIG_LOW  = 3'd0;
  localparam logic [2:0] TRIG_HIGH = 3'd1;
  localparam logic [2:0] TRIG_FALL = 3'd2;
  localparam logic [2:0] TRIG_RISE = 3'd3;
  localparam logic [2:0] TRIG_NONE = 3'd4;
  localparam logic [2:0] TRIG_ANY  = 3'd6;

  localparam logic [11:0] OFF_STAT     = 12'h310;
  localparam logic [11:0] OFF_EN       = 12'h314;
  localparam logic [11:0] OFF_CLR      = 12'h318;
  localparam logic [11:0] OFF_ROUTE    = 12'h31C;
  localparam int unsigned CFG_BASE     = 'h330;
  localparam int unsigned CFG_STRIDE   = 8;

  // route register field positions
  localparam int unsigned RT_PER_IRQ  = 0;
  localparam int unsigned RT_PIN_IRQ  = 8;
  localparam int unsigned RT_PER_WAKE = 16;
  localparam int unsigned RT_PIN_WAKE = 24;
endpackage

// File: rtl/wkp_sync.sv
module wkp_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      sync_o  <= '0;
    end else begin
      stage_q <= async_i;
      sync_o  <= stage_q;
    end
  end
endmodule

// File: rtl/wkp_trig.sv
module wkp_trig
  import wkp_pkg::*;
#(
  parameter int unsigned NPINS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NPINS-1:0]      lvl_i,
  input  logic [NPINS-1:0][2:0] mode_i,
  input  logic [NPINS-1:0]      hold_i,
  input  logic [NPINS-1:0]      clr_i,
  output logic [NPINS-1:0]      stat_o
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic prev_q, stat_q, stat_d;
    logic rise, fall, keep;

    assign rise = lvl_i[i] & ~prev_q;
    assign fall = ~lvl_i[i] & prev_q;
    assign keep = stat_q & ~clr_i[i];

    always_comb begin
      unique case (mode_i[i])
        TRIG_LOW:  stat_d = ~lvl_i[i];
        TRIG_HIGH: stat_d = lvl_i[i];
        TRIG_FALL: stat_d = fall | keep;
        TRIG_RISE: stat_d = rise | keep;
        TRIG_ANY:  stat_d = rise | fall | keep;
        default:   stat_d = keep;
      endcase
      if (hold_i[i]) stat_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        stat_q <= 1'b0;
      end else begin
        prev_q <= lvl_i[i];
        stat_q <= stat_d;
      end
    end

    assign stat_o[i] = stat_q;

    a_r3_edge_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_i[i] == TRIG_RISE || mode_i[i] == TRIG_FALL || mode_i[i] == TRIG_ANY)
       && stat_q && !clr_i[i] && !hold_i[i]) |=> stat_q);

    a_r6_none_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i][2] && mode_i[i] != TRIG_ANY && !stat_q) |=> !stat_q);

    a_r10_hold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i[i] |=> !stat_q);

    a_r5_level_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] == TRIG_HIGH && lvl_i[i] && !hold_i[i]) |=> stat_q);

    a_r7_clear_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] == TRIG_RISE && rise && clr_i[i] && !hold_i[i]) |=> stat_q);
  end
endmodule

// File: rtl/wkp_regs.sv
module wkp_regs
  import wkp_pkg::*;
#(
  parameter int unsigned NPINS  = 4,
  parameter int unsigned NPERIP = 3,
  parameter int unsigned AW     = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         addr_i,
  input  logic                  we_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  input  logic [NPINS-1:0]      lvl_i,
  input  logic [NPINS-1:0]      stat_i,
  output logic [NPINS-1:0][2:0] mode_o,
  output logic [NPINS-1:0]      hold_o,
  output logic [NPINS-1:0]      clr_o,
  output logic [NPINS-1:0]      en_o,
  output logic [NPINS-1:0]      rt_pin_irq_o,
  output logic [NPINS-1:0]      rt_pin_wake_o,
  output logic [NPERIP-1:0]     rt_per_irq_o,
  output logic [NPERIP-1:0]     rt_per_wake_o
);
  logic hit_en, hit_stat, hit_clr, hit_route;
  logic [NPINS-1:0] hit_cfg;
  logic unused_wd;

  assign unused_wd = ^wdata_i;
  assign hit_stat  = (addr_i == AW'(OFF_STAT));
  assign hit_en    = (addr_i == AW'(OFF_EN));
  assign hit_clr   = (addr_i == AW'(OFF_CLR));
  assign hit_route = (addr_i == AW'(OFF_ROUTE));

  assign clr_o = (we_i && hit_clr) ? wdata_i[NPINS-1:0] : '0;

  for (genvar i = 0; i < NPINS; i++) begin : g_cfg
    localparam logic [AW-1:0] A_CFG = AW'(CFG_BASE + CFG_STRIDE * i);
    assign hit_cfg[i] = (addr_i == A_CFG);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_o[i] <= TRIG_NONE;
        hold_o[i] <= 1'b0;
      end else if (we_i && hit_cfg[i]) begin
        mode_o[i] <= wdata_i[3:1];
        hold_o[i] <= wdata_i[4];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o          <= '0;
      rt_pin_irq_o  <= '0;
      rt_pin_wake_o <= '0;
      rt_per_irq_o  <= '0;
      rt_per_wake_o <= '0;
    end else if (we_i) begin
      if (hit_en) en_o <= wdata_i[NPINS-1:0];
      if (hit_route) begin
        rt_pin_irq_o  <= wdata_i[RT_PIN_IRQ  +: NPINS];
        rt_pin_wake_o <= wdata_i[RT_PIN_WAKE +: NPINS];
        rt_per_irq_o  <= wdata_i[RT_PER_IRQ  +: NPERIP];
        rt_per_wake_o <= wdata_i[RT_PER_WAKE +: NPERIP];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_stat) rdata_o[NPINS-1:0] = stat_i;
    if (hit_en)   rdata_o[NPINS-1:0] = en_o;
    if (hit_route) begin
      rdata_o[RT_PIN_IRQ  +: NPINS]  = rt_pin_irq_o;
      rdata_o[RT_PIN_WAKE +: NPINS]  = rt_pin_wake_o;
      rdata_o[RT_PER_IRQ  +: NPERIP] = rt_per_irq_o;
      rdata_o[RT_PER_WAKE +: NPERIP] = rt_per_wake_o;
    end
    for (int i = 0; i < NPINS; i++) begin
      if (hit_cfg[i]) rdata_o[4:0] = {hold_o[i], mode_o[i], lvl_i[i]};
    end
  end

  a_r7_clear_zero_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_clr && wdata_i[NPINS-1:0] == '0) |-> (clr_o == '0));
endmodule

// File: rtl/wkp_route.sv
module wkp_route #(
  parameter int unsigned NPINS  = 4,
  parameter int unsigned NPERIP = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  stat_i,
  input  logic [NPINS-1:0]  en_i,
  input  logic [NPERIP-1:0] perip_i,
  input  logic [NPINS-1:0]  rt_pin_irq_i,
  input  logic [NPINS-1:0]  rt_pin_wake_i,
  input  logic [NPERIP-1:0] rt_per_irq_i,
  input  logic [NPERIP-1:0] rt_per_wake_i,
  output logic              irq_o,
  output logic              wake_o
);
  logic [NPINS-1:0] pend;
  logic irq_d, wake_d;

  assign pend   = stat_i & en_i;
  assign irq_d  = |(pend & rt_pin_irq_i)  | |(perip_i & rt_per_irq_i);
  assign wake_d = |(pend & rt_pin_wake_i) | |(perip_i & rt_per_wake_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= irq_d;
      wake_o <= wake_d;
    end
  end

  a_r12_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0 && perip_i == '0) |=> (!irq_o && !wake_o));

  a_r9_wake_needs_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_pin_wake_i == '0 && rt_per_wake_i == '0) |=> !wake_o);

  a_r8_irq_needs_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_pin_irq_i == '0 && rt_per_irq_i == '0) |=> !irq_o);
endmodule

// File: rtl/wake_pin_ctrl.sv
module wake_pin_ctrl
  import wkp_pkg::*;
#(
  parameter int unsigned NPINS  = 4,
  parameter int unsigned NPERIP = 3,
  parameter int unsigned AW     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NPINS-1:0]  wake_pin_i,
  input  logic [NPERIP-1:0] perip_evt_i,
  output logic              irq_o,
  output logic              wake_o
);
  logic [NPINS-1:0]      lvl, stat, hold, clr, en;
  logic [NPINS-1:0][2:0] mode;
  logic [NPINS-1:0]      rt_pin_irq, rt_pin_wake;
  logic [NPERIP-1:0]     rt_per_irq, rt_per_wake;

  wkp_sync #(.W(NPINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(wake_pin_i), .sync_o(lvl)
  );

  wkp_regs #(.NPINS(NPINS), .NPERIP(NPERIP), .AW(AW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .lvl_i(lvl), .stat_i(stat),
    .mode_o(mode), .hold_o(hold), .clr_o(clr), .en_o(en),
    .rt_pin_irq_o(rt_pin_irq), .rt_pin_wake_o(rt_pin_wake),
    .rt_per_irq_o(rt_per_irq), .rt_per_wake_o(rt_per_wake)
  );

  wkp_trig #(.NPINS(NPINS)) u_trig (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .mode_i(mode),
    .hold_i(hold), .clr_i(clr), .stat_o(stat)
  );

  wkp_route #(.NPINS(NPINS), .NPERIP(NPERIP)) u_route (
    .clk_i(clk_i), .rst_ni(rst_ni), .stat_i(stat), .en_i(en),
    .perip_i(perip_evt_i), .rt_pin_irq_i(rt_pin_irq),
    .rt_pin_wake_i(rt_pin_wake), .rt_per_irq_i(rt_per_irq),
    .rt_per_wake_i(rt_per_wake), .irq_o(irq_o), .wake_o(wake_o)
  );

  initial begin
    a_r2_pin_limit: assert (NPINS >= 1 && NPINS <= 4);
  end
endmodule

// File: tb/wake_pin_ctrl_bench.sv
module wake_pin_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  wake_pin_i = '0;
  logic [2:0]  perip_evt_i = '0;
  logic        irq_o, wake_o;

  int total = 0;
  int bad = 0;
  int glitches;
  logic [31:0] rd;

  localparam logic [11:0] A_STAT  = 12'h310;
  localparam logic [11:0] A_EN    = 12'h314;
  localparam logic [11:0] A_CLR   = 12'h318;
  localparam logic [11:0] A_ROUTE = 12'h31C;

  // {mode[2:0], pin before clear, pin after clear, expected status}
  localparam int NV = 15;
  localparam logic [5:0] VEC [NV] = '{
    {3'd3, 1'b0, 1'b1, 1'b1},  // R3 rise seen
    {3'd3, 1'b1, 1'b0, 1'b0},  // R3 clear sticks, fall ignored
    {3'd2, 1'b1, 1'b0, 1'b1},  // R4 fall
    {3'd2, 1'b0, 1'b1, 1'b0},  // R4
    {3'd6, 1'b0, 1'b1, 1'b1},  // R4 either
    {3'd6, 1'b1, 1'b0, 1'b1},  // R4 either
    {3'd6, 1'b0, 1'b0, 1'b0},  // R4 steady
    {3'd1, 1'b0, 1'b1, 1'b1},  // R5 high
    {3'd1, 1'b1, 1'b0, 1'b0},  // R5
    {3'd0, 1'b1, 1'b0, 1'b1},  // R5 low
    {3'd0, 1'b0, 1'b1, 1'b0},  // R5
    {3'd4, 1'b0, 1'b1, 1'b0},  // R6
    {3'd4, 1'b1, 1'b0, 1'b0},  // R6
    {3'd5, 1'b0, 1'b1, 1'b0},  // R6
    {3'd7, 1'b1, 1'b0, 1'b0}   // R6
  };

  wake_pin_ctrl u_wake_pin_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .wake_pin_i(wake_pin_i),
    .perip_evt_i(perip_evt_i), .irq_o(irq_o), .wake_o(wake_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rdr(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        bad++;
        $display("FAIL watchdog act=%0d exp=<100000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(2);

    // R1 reset state
    rdr(12'h330, rd); chk("R1 cfg0", rd, 32'h8);
    rdr(A_STAT, rd);  chk("R1 status", rd, 0);
    rdr(A_EN, rd);    chk("R1 enable", rd, 0);
    rdr(A_ROUTE, rd); chk("R1 route", rd, 0);
    chk("R1 outputs", {30'd0, irq_o, wake_o}, 0);

    // R3..R6 table walk on pin 0
    for (int v = 0; v < NV; v++) begin
      wr(12'h330, {28'd0, VEC[v][5:3], 1'b0});
      wake_pin_i[0] = VEC[v][2];
      tick(5);
      wr(A_CLR, 32'h1);
      tick(5);
      wake_pin_i[0] = VEC[v][1];
      tick(5);
      rdr(A_STAT, rd);
      chk($sformatf("R3-6 vec%0d mode%0d", v, VEC[v][5:3]), {31'd0, rd[0]}, {31'd0, VEC[v][0]});
    end

    // R2 config readback
    wr(12'h338, 32'hFFFF_FFFF);
    rdr(12'h338, rd); chk("R2 cfg1 fields", rd, 32'h1E);
    wake_pin_i[1] = 1'b1;
    tick(4);
    rdr(12'h338, rd); chk("R2 cfg1 level", rd, 32'h1F);
    wr(12'h338, 32'h8);
    wake_pin_i[1] = 1'b0;

    // R7 write 0 inert, clear vs edge same cycle
    wake_pin_i[0] = 1'b0;
    wr(12'h330, 32'h6);  // rising
    tick(5);
    wr(A_CLR, 32'h1);
    wake_pin_i[0] = 1'b1;
    tick(5);
    wr(A_CLR, 32'h0);
    rdr(A_STAT, rd); chk("R7 clear zero", {31'd0, rd[0]}, 1);
    wr(A_CLR, 32'h1);
    wake_pin_i[0] = 1'b0;
    tick(5);
    rdr(A_STAT, rd); chk("R7 precondition", {31'd0, rd[0]}, 0);
    @(negedge clk_i); wake_pin_i[0] = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i); addr_i = A_CLR; wdata_i = 32'h1; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0;
    tick(2);
    rdr(A_STAT, rd); chk("R7 clear+edge", {31'd0, rd[0]}, 1);

    // R8 interrupt routing (pin0 status is 1)
    wr(A_EN, 32'h1);
    wr(A_ROUTE, 32'h100);
    tick(3);
    chk("R8 pin irq", {30'd0, irq_o, wake_o}, 32'h2);
    wr(A_EN, 32'h0);
    tick(3);
    chk("R8 enable off", {30'd0, irq_o, wake_o}, 0);
    // R9 wake routing
    wr(A_EN, 32'h1);
    wr(A_ROUTE, 32'h0100_0000);
    tick(3);
    chk("R9 pin wake", {30'd0, irq_o, wake_o}, 32'h1);
    wr(A_EN, 32'h0);
    wr(A_ROUTE, 32'h1);
    perip_evt_i = 3'b001;
    tick(3);
    chk("R8 rtc irq", {30'd0, irq_o, wake_o}, 32'h2);
    wr(A_ROUTE, 32'h0004_0000);
    perip_evt_i = 3'b100;
    tick(3);
    chk("R9 wd wake", {30'd0, irq_o, wake_o}, 32'h1);
    perip_evt_i = 3'b000;
    wr(12'h330, 32'h8);
    wr(A_CLR, 32'hF);

    // R10 hold bit
    wr(12'h340, 32'h12);  // level high + hold
    wake_pin_i[2] = 1'b1;
    tick(5);
    rdr(A_STAT, rd); chk("R10 hold", {31'd0, rd[2]}, 0);
    wr(12'h340, 32'h2);
    tick(3);
    rdr(A_STAT, rd); chk("R10 release", {31'd0, rd[2]}, 1);
    wr(12'h340, 32'h8);
    wake_pin_i[2] = 1'b0;
    wr(A_CLR, 32'hF);

    // R11 route bits, reserved and unmapped
    wr(A_ROUTE, 32'hFFFF_FFFF);
    rdr(A_ROUTE, rd); chk("R11 route mask", rd, 32'h0F07_0F07);
    wr(12'h334, 32'hFFFF_FFFF);
    rdr(12'h334, rd); chk("R11 second per-pin", rd, 0);
    wr(12'h320, 32'hFFFF_FFFF);
    rdr(12'h320, rd); chk("R11 unmapped", rd, 0);
    rdr(A_CLR, rd);   chk("R11 clear reads 0", rd, 0);
    wr(A_ROUTE, 32'h0);

    // R12 quiet setup sequence
    glitches = 0;
    for (int p = 0; p < 4; p++) wr(12'(12'h330 + 8 * p), 32'h8);
    wr(A_EN, 32'h0);
    wr(A_ROUTE, 32'h0F07_0F07);
    for (int t = 0; t < 40; t++) begin
      wake_pin_i = 4'(t * 5 + 3);
      @(negedge clk_i);
      if (irq_o || wake_o) glitches++;
    end
    chk("R12 spurious", glitches, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule